// File: doc/BRIEF.md
# UART Receive Character Buffer

This block is the receive-side store of one serial channel. A receiver front end hands it complete characters, each with three error flags: framing, parity and break. The buffer holds them in a show-ahead FIFO whose capacity is set by one configuration bit, either the shallow depth of 8 or the deep depth of 256. The host reads the character at the head and pops it when done.

The buffer raises an interrupt when its fill reaches a programmable level. The level is a 2-bit code whose thresholds depend on the selected depth. An inactivity watchdog can also raise the interrupt when characters sit unread for 64 receiver bit times. For hardware flow control, an RTS output goes inactive when a new start bit is seen while the store is full, and it comes back by itself once a slot frees. Error status is reported in one of two ways: per character, showing the flags of the head entry only, or accumulated, showing the sticky OR of the flags of every entry that has reached the head since the last error-clear.

Top module: `uart_rx_buffer`

## Requirements
- R1: With `cfg_deep`=0 the buffer holds at most 8 characters; with `cfg_deep`=1 it holds at most 256. `fill` never exceeds the selected capacity.
- R2: Characters leave in arrival order. `rd_data` shows the oldest character, and a `pop` removes it. A `pop` while `fill` is 0 has no effect.
- R3: A character presented while the buffer is full, with no `pop` in the same cycle, is discarded and sets `ovr_flag` from the next cycle. The flag stays set until an `err_clr` pulse.
- R4: In shallow mode the level interrupt is active while `fill` is at least the threshold for `cfg_lvl`: 0 gives 1, 1 gives 3, 2 gives 6 and 3 gives 8.
- R5: In deep mode the same `cfg_lvl` codes give thresholds of 1, 128, 192 and 256.
- R6: With `cfg_wdog_en`=1 and `fill` above 0, 64 `bit_tick` pulses with no push and no pop raise `irq`. The next `pop` withdraws it. A push or a pop restarts the count. With `cfg_wdog_en`=0 the watchdog never raises `irq`, and `irq` is never active while `fill` is 0.
- R7: With `cfg_rts_en`=1, an `rx_start` pulse while the buffer is full drives `rts_n` high from the next cycle. `rts_n` returns low in the cycle after a pop leaves the buffer below capacity. With `cfg_rts_en`=0, `rts_n` stays low.
- R8: With `cfg_blk_err`=0, `err_st` ({break, parity, framing}, bit 0 = framing) equals the flags stored with the head character, and is 0 while `fill` is 0.
- R9: With `cfg_blk_err`=1, `err_st` is the OR of the flags of every character that has reached the head since the last `err_clr`. An `err_clr` pulse returns it to 0.
- R10: After reset, `fill`, `irq`, `rts_n`, `ovr_flag` and `err_st` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_deep | input | 1 | 1 selects the deep capacity, 0 the shallow capacity |
| cfg_lvl | input | 2 | Interrupt level code |
| cfg_wdog_en | input | 1 | Watchdog enable |
| cfg_rts_en | input | 1 | Flow-control enable for `rts_n` |
| cfg_blk_err | input | 1 | 1 selects accumulated error status, 0 selects per-character status |
| rx_valid | input | 1 | Completed character strobe |
| rx_data | input | 8 | Character value |
| rx_flags | input | 3 | {break, parity, framing} of the character |
| rx_start | input | 1 | Start bit detected strobe |
| bit_tick | input | 1 | One pulse per receiver bit time |
| pop | input | 1 | Host removes the head character |
| err_clr | input | 1 | Clears accumulated status and the overrun flag |
| rd_data | output | 8 | Head character |
| err_st | output | 3 | Error status {break, parity, framing} |
| fill | output | 9 | Characters held |
| irq | output | 1 | Level or watchdog interrupt |
| ovr_flag | output | 1 | Overrun occurred |
| rts_n | output | 1 | Flow control, high = stop sending |

## Verification
The bench builds the block with the default depths, 8 and 256, so both capacities are reached by switching `cfg_deep` at run time. This lets the bench fill the store to 256, check every level code just below and at each deep threshold, and cause an overrun at both sizes. The 64-tick watchdog window is driven with `bit_tick` held high. This places the edge of the window exactly one cycle apart from its last quiet cycle.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  localparam int FLAG_W = 3;
  // flag vector order: [2] break, [1] parity, [0] framing
  typedef logic [FLAG_W-1:0] rxb_flags_t;
endpackage

// File: rtl/rxb_store.sv
module rxb_store #(
  parameter int DEPTH  = 256,
  parameter int WIDTH  = 11,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
  end

  assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/rxb_level.sv
module rxb_level #(
  parameter int DEEP    = 256,
  parameter int SHALLOW = 8,
  localparam int CW     = $clog2(DEEP + 1)
) (
  input  logic          deep,
  input  logic [1:0]    code,
  input  logic [CW-1:0] count,
  output logic          hit
);
  localparam logic [CW-1:0] S1 = CW'(SHALLOW * 3 / 8);
  localparam logic [CW-1:0] S2 = CW'(SHALLOW * 3 / 4);
  localparam logic [CW-1:0] S3 = CW'(SHALLOW);
  localparam logic [CW-1:0] D1 = CW'(DEEP / 2);
  localparam logic [CW-1:0] D2 = CW'(DEEP * 3 / 4);
  localparam logic [CW-1:0] D3 = CW'(DEEP);

  logic [CW-1:0] thr;

  always_comb begin
    unique case (code)
      2'd0:    thr = CW'(1);
      2'd1:    thr = deep ? D1 : S1;
      2'd2:    thr = deep ? D2 : S2;
      default: thr = deep ? D3 : S3;
    endcase
  end

  assign hit = (count >= thr);
endmodule

// File: rtl/rxb_wdog.sv
module rxb_wdog #(
  parameter int WINDOW = 64,
  localparam int WCW   = $clog2(WINDOW)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic armed,
  input  logic tick,
  input  logic kick,
  input  logic clr,
  output logic fire
);
  logic [WCW-1:0] cnt_q, cnt_d;
  logic           fire_q, fire_d;

  always_comb begin
    cnt_d  = cnt_q;
    fire_d = fire_q;
    if (!en) begin
      cnt_d  = '0;
      fire_d = 1'b0;
    end else if (kick) begin
      cnt_d = '0;
      if (clr) fire_d = 1'b0;
    end else if (armed && tick && !fire_q) begin
      if (cnt_q == WCW'(WINDOW - 1)) begin
        cnt_d  = '0;
        fire_d = 1'b1;
      end else begin
        cnt_d = cnt_q + WCW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      fire_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      fire_q <= fire_d;
    end
  end

  assign fire = fire_q;
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer #(
  parameter int DATA_W  = 8,
  parameter int DEEP    = 256,
  parameter int SHALLOW = 8,
  parameter int WDOG_BT = 64,
  localparam int AW     = $clog2(DEEP),
  localparam int CW     = $clog2(DEEP + 1),
  localparam int EW     = DATA_W + rxb_pkg::FLAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_deep,
  input  logic [1:0]        cfg_lvl,
  input  logic              cfg_wdog_en,
  input  logic              cfg_rts_en,
  input  logic              cfg_blk_err,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [2:0]        rx_flags,
  input  logic              rx_start,
  input  logic              bit_tick,
  input  logic              pop,
  input  logic              err_clr,
  output logic [DATA_W-1:0] rd_data,
  output logic [2:0]        err_st,
  output logic [CW-1:0]     fill,
  output logic              irq,
  output logic              ovr_flag,
  output logic              rts_n
);
  import rxb_pkg::*;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i = rsync_q[1];

  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d, cap;
  logic          empty, full, full_d, pop_ok, push_ok, lost, arrive;
  logic          ovr_q, ovr_d, hold_q, hold_d, hnew_q, hnew_d;
  rxb_flags_t    acc_q, acc_d, head_fl;
  logic [EW-1:0] head_ent;
  logic          lvl_hit, wd_fire;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p,
                                             input logic [CW-1:0] c);
    return (CW'(p) == c - CW'(1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    cap     = cfg_deep ? CW'(DEEP) : CW'(SHALLOW);
    empty   = (cnt_q == '0);
    full    = (cnt_q == cap);
    pop_ok  = pop && !empty;
    push_ok = rx_valid && (!full || pop_ok);
    lost    = rx_valid && full && !pop_ok;
    cnt_d   = cnt_q + CW'(push_ok) - CW'(pop_ok);
    full_d  = (cnt_d == cap);
    wp_d    = push_ok ? wrap_inc(wp_q, cap) : wp_q;
    rp_d    = pop_ok  ? wrap_inc(rp_q, cap) : rp_q;
    // a new entry becomes the head when the store was empty or the head left
    arrive  = (cnt_d != '0) && (pop_ok || empty);
    hnew_d  = arrive;
    head_fl = empty ? '0 : head_ent[EW-1 -: FLAG_W];
    acc_d   = err_clr ? '0 : (acc_q | (hnew_q ? head_fl : '0));
    ovr_d   = (ovr_q && !err_clr) || lost;
    hold_d  = cfg_rts_en && full_d && (hold_q || (rx_start && full));
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      wp_q   <= '0;
      rp_q   <= '0;
      cnt_q  <= '0;
      ovr_q  <= 1'b0;
      hold_q <= 1'b0;
      hnew_q <= 1'b0;
      acc_q  <= '0;
    end else begin
      wp_q   <= wp_d;
      rp_q   <= rp_d;
      cnt_q  <= cnt_d;
      ovr_q  <= ovr_d;
      hold_q <= hold_d;
      hnew_q <= hnew_d;
      acc_q  <= acc_d;
    end
  end

  rxb_store #(.DEPTH(DEEP), .WIDTH(EW)) u_store (
    .clk     (clk),
    .wr_en   (push_ok),
    .wr_addr (wp_q),
    .wr_data ({rx_flags, rx_data}),
    .rd_addr (rp_q),
    .rd_data (head_ent)
  );

  rxb_level #(.DEEP(DEEP), .SHALLOW(SHALLOW)) u_level (
    .deep  (cfg_deep),
    .code  (cfg_lvl),
    .count (cnt_q),
    .hit   (lvl_hit)
  );

  rxb_wdog #(.WINDOW(WDOG_BT)) u_wdog (
    .clk   (clk),
    .rst_n (rst_i),
    .en    (cfg_wdog_en),
    .armed (!empty),
    .tick  (bit_tick),
    .kick  (push_ok || pop_ok),
    .clr   (pop_ok),
    .fire  (wd_fire)
  );

  assign rd_data  = head_ent[DATA_W-1:0];
  assign err_st   = cfg_blk_err ? (acc_q | (hnew_q ? head_fl : '0)) : head_fl;
  assign fill     = cnt_q;
  assign irq      = lvl_hit || wd_fire;
  assign ovr_flag = ovr_q;
  assign rts_n    = hold_q;
endmodule

// File: rtl/rxb_checker.sv
module rxb_checker #(
  parameter int DEEP    = 256,
  parameter int SHALLOW = 8,
  localparam int CW     = $clog2(DEEP + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_deep,
  input logic          cfg_rts_en,
  input logic          cfg_blk_err,
  input logic          rx_valid,
  input logic          rx_start,
  input logic          pop,
  input logic [2:0]    err_st,
  input logic [CW-1:0] fill,
  input logic          irq,
  input logic          ovr_flag,
  input logic          rts_n
);
  logic [CW-1:0] cap;
  assign cap = cfg_deep ? CW'(DEEP) : CW'(SHALLOW);

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= cap); // R1
  AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == $past(fill)) || (fill == $past(fill) + CW'(1)) || (fill + CW'(1) == $past(fill))); // R2
  AST_OVR_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !pop && (fill == cap) |=> ovr_flag); // R3
  AST_IRQ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == '0) |-> !irq); // R6
  AST_RTS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rts_en && rx_start && !pop && (fill == cap) |=> rts_n); // R7
  AST_RTS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rts_en |=> !rts_n); // R7
  AST_CHR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_blk_err && (fill == '0) |-> (err_st == 3'b000)); // R8
endmodule

bind uart_rx_buffer rxb_checker #(.DEEP(DEEP), .SHALLOW(SHALLOW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_deep    (cfg_deep),
  .cfg_rts_en  (cfg_rts_en),
  .cfg_blk_err (cfg_blk_err),
  .rx_valid    (rx_valid),
  .rx_start    (rx_start),
  .pop         (pop),
  .err_st      (err_st),
  .fill        (fill),
  .irq         (irq),
  .ovr_flag    (ovr_flag),
  .rts_n       (rts_n)
);

// File: tb/sim_uart_rx_buffer.sv
module sim_uart_rx_buffer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_deep = 1'b0, cfg_wdog_en = 1'b0, cfg_rts_en = 1'b0, cfg_blk_err = 1'b0;
  logic [1:0] cfg_lvl = 2'd0;
  logic       rx_valid = 1'b0, rx_start = 1'b0, bit_tick = 1'b0, pop = 1'b0, err_clr = 1'b0;
  logic [7:0] rx_data = 8'd0;
  logic [2:0] rx_flags = 3'd0;
  logic [7:0] rd_data;
  logic [2:0] err_st;
  logic [8:0] fill;
  logic       irq, ovr_flag, rts_n;
  int         n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  uart_rx_buffer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_deep(cfg_deep), .cfg_lvl(cfg_lvl),
    .cfg_wdog_en(cfg_wdog_en), .cfg_rts_en(cfg_rts_en), .cfg_blk_err(cfg_blk_err),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_flags(rx_flags), .rx_start(rx_start),
    .bit_tick(bit_tick), .pop(pop), .err_clr(err_clr), .rd_data(rd_data),
    .err_st(err_st), .fill(fill), .irq(irq), .ovr_flag(ovr_flag), .rts_n(rts_n)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] d, input logic [2:0] f);
    rx_valid = 1'b1; rx_data = d; rx_flags = f;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic pop1();
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
  endtask

  task automatic pulse_clr();
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
  endtask

  task automatic pulse_start();
    rx_start = 1'b1;
    @(negedge clk);
    rx_start = 1'b0;
  endtask

  function automatic int thr_of(input logic deep, input int code);
    int s[4] = '{1, 3, 6, 8};
    int d[4] = '{1, 128, 192, 256};
    return deep ? d[code] : s[code];
  endfunction

  task automatic lvl_sweep(input string req, input logic deep, input int n);
    for (int c = 0; c < 4; c++) begin
      cfg_lvl = 2'(c);
      #1;
      check(req, int'(irq), int'(n >= thr_of(deep, c)));
    end
    cfg_lvl = 2'd0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R10 fill", int'(fill), 0);
    check("R10 irq", int'(irq), 0);
    check("R10 rts_n", int'(rts_n), 0);
    check("R10 ovr", int'(ovr_flag), 0);
    check("R10 err_st", int'(err_st), 0);
  endtask

  task automatic t_order();
    do_reset();
    push(8'h11, 3'b000); push(8'h22, 3'b000); push(8'h33, 3'b000);
    check("R2 head", int'(rd_data), 'h11);
    pop1();
    check("R2 second", int'(rd_data), 'h22);
    check("R2 fill", int'(fill), 2);
    pop1(); pop1();
    check("R2 drained", int'(fill), 0);
    pop1();
    check("R2 pop empty", int'(fill), 0);
    push(8'h44, 3'b000);
    check("R2 after empty pop", int'(rd_data), 'h44);
    check("R2 fill one", int'(fill), 1);
  endtask

  task automatic t_shallow();
    do_reset();
    cfg_deep = 1'b0;
    for (int i = 1; i <= 8; i++) begin
      push(8'(i), 3'b000);
      lvl_sweep("R4", 1'b0, i);
    end
    check("R1 shallow full", int'(fill), 8);
    check("R3 no ovr yet", int'(ovr_flag), 0);
    push(8'hEE, 3'b000);
    check("R1 shallow cap", int'(fill), 8);
    check("R3 ovr set", int'(ovr_flag), 1);
    pulse_clr();
    check("R3 ovr cleared", int'(ovr_flag), 0);
    for (int i = 1; i <= 8; i++) begin
      check("R2 shallow order", int'(rd_data), i);
      pop1();
    end
    check("R3 lost char absent", int'(fill), 0);
  endtask

  task automatic t_deep();
    do_reset();
    cfg_deep = 1'b1;
    for (int i = 1; i <= 256; i++) begin
      push(8'(i), 3'b000);
      if (i == 1 || i == 127 || i == 128 || i == 191 || i == 192 || i == 255 || i == 256)
        lvl_sweep("R5", 1'b1, i);
    end
    check("R1 deep full", int'(fill), 256);
    push(8'h77, 3'b000);
    check("R1 deep cap", int'(fill), 256);
    check("R3 deep ovr", int'(ovr_flag), 1);
    check("R2 deep head", int'(rd_data), 1);
    cfg_deep = 1'b0;
  endtask

  task automatic t_wdog();
    do_reset();
    cfg_lvl = 2'd3; cfg_wdog_en = 1'b1; bit_tick = 1'b1;
    push(8'h01, 3'b000); push(8'h02, 3'b000);
    for (int i = 1; i <= 63; i++) @(negedge clk);
    check("R6 quiet 63", int'(irq), 0);
    @(negedge clk);
    check("R6 fires 64", int'(irq), 1);
    pop1();
    check("R6 pop clears", int'(irq), 0);
    check("R6 fill after pop", int'(fill), 1);
    repeat (30) @(negedge clk);
    push(8'h03, 3'b000);
    repeat (40) @(negedge clk);
    check("R6 push restarts", int'(irq), 0);
    do_reset();
    cfg_wdog_en = 1'b0;
    push(8'h05, 3'b000);
    repeat (100) @(negedge clk);
    check("R6 disabled", int'(irq), 0);
    bit_tick = 1'b0; cfg_lvl = 2'd0;
  endtask

  task automatic t_rts();
    do_reset();
    cfg_rts_en = 1'b1;
    for (int i = 0; i < 7; i++) push(8'(i), 3'b000);
    pulse_start();
    check("R7 not full", int'(rts_n), 0);
    push(8'h07, 3'b000);
    pulse_start();
    check("R7 negated", int'(rts_n), 1);
    @(negedge clk);
    check("R7 held", int'(rts_n), 1);
    pop1();
    check("R7 reasserted", int'(rts_n), 0);
    push(8'h08, 3'b000);
    cfg_rts_en = 1'b0;
    pulse_start();
    check("R7 disabled", int'(rts_n), 0);
  endtask

  task automatic t_err();
    do_reset();
    cfg_blk_err = 1'b0;
    push(8'hA1, 3'b001); push(8'hA2, 3'b010); push(8'hA3, 3'b100);
    check("R8 head fe", int'(err_st), 1);
    pop1();
    check("R8 head pe", int'(err_st), 2);
    pop1();
    check("R8 head brk", int'(err_st), 4);
    pop1();
    check("R8 empty", int'(err_st), 0);
    cfg_blk_err = 1'b1;
    pulse_clr();
    push(8'hB1, 3'b001); push(8'hB2, 3'b010); push(8'hB3, 3'b000);
    check("R9 first", int'(err_st), 1);
    pop1();
    check("R9 or two", int'(err_st), 3);
    pop1();
    check("R9 sticky", int'(err_st), 3);
    pulse_clr();
    check("R9 cleared", int'(err_st), 0);
    push(8'hB4, 3'b100);
    check("R9 tail unseen", int'(err_st), 0);
    pop1();
    check("R9 brk reached head", int'(err_st), 4);
    cfg_blk_err = 1'b0;
  endtask

  initial begin
    t_reset();
    t_order();
    t_shallow();
    t_deep();
    t_wdog();
    t_rts();
    t_err();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule